// File: doc/BRIEF.md
# Framed Serial DAC Input Controller

This block is the digital front end of a low-power voltage DAC. A host writes it over three wires: an active-low frame select, a serial clock and a data line. The block samples all three in its own system clock domain, assembles a 16-bit command word most significant bit first, and acts on it only when the sixteenth falling serial-clock edge of a frame has arrived. A frame that is cut short by the frame select rising early is thrown away without touching any state.

The command word holds a two-bit power-mode field in its top bits and a 14-bit data field below. A normal-mode command loads the DAC code register from the top bits of the data field. A power-down command changes only the output termination and the power-down enable, and the stored code is kept so that the output returns to the same level when the host later selects normal mode. A one-cycle pulse marks each executed command and another marks each aborted frame.

Top module: `sdac_frontend`

## Requirements
- R1: After reset the code output is zero, the power-down enable is low, the termination select is 00, and neither pulse output is high.
- R2: Bits are taken on falling serial-clock edges, first bit into word bit 15; the code loaded is word bits 13 down to 14-CODE_W (with CODE_W=12, bits 13..2), and word bits below that are ignored.
- R3: On the sixteenth falling clock edge of a frame the command executes once: the frame-valid output pulses for exactly one system clock in the same cycle the new code and mode first appear.
- R4: If the frame select rises after 1 to 15 falling clock edges, the aborted output pulses once and the code, mode and power-down outputs keep their values; a rise after zero edges gives no pulse at all.
- R5: Word bits 15:14 set the mode: 00 normal, 01 power-down with low-value load, 10 power-down with high-value load, 11 power-down with the output open. The termination select output equals this field and the power-down enable is high whenever it is not 00.
- R6: A command with a non-zero mode field leaves the code register unchanged; only a mode-00 command writes the code.
- R7: After a completed frame, further clock edges while the frame select stays low have no effect and raise no pulse; a new frame needs the frame select to go high and then low again.
- R8: An aborted frame leaves no residue: the next complete frame loads exactly its own bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host, data taken on its falling edge |
| sdin | input | 1 | Serial data from the host, MSB first |
| code_o | output | CODE_W | Stored DAC code |
| pwr_dn_o | output | 1 | High when a power-down mode is selected |
| term_sel_o | output | 2 | Output termination select (the mode field) |
| frame_ok_o | output | 1 | One-cycle pulse when a command executes |
| frame_abort_o | output | 1 | One-cycle pulse when a partial frame is discarded |

## Verification
A wrong bit counter or a stale shift register shows up on the next frame: the code output carries a shifted or mixed value, or a pulse appears on the wrong output, within a few system clocks after the frame select rises. A mode register that drifts from the power-down enable is visible at once, since both come out as ports, and a power-down command that wrongly writes the code is caught when normal mode is restored. Random frames of random lengths, some with trailing clocks, are checked against a model after every frame, together with directed cases for full scale, ignored low bits, zero-length frames and recovery after an abort.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int WORD_W = 16;
    localparam int DATA_W = 14;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        MODE_RUN     = 2'b00,
        MODE_PD_LOW  = 2'b01,
        MODE_PD_HIGH = 2'b10,
        MODE_PD_OPEN = 2'b11
    } mode_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_i,
    input  logic              sc_i,
    input  logic              sd_i,
    output logic              cmd_vld_o,
    output logic [WORD_W-1:0] cmd_o,
    output logic              abort_o
);
    typedef struct packed {
        logic              prev_fs;
        logic              prev_sc;
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] cmd;
        logic              vld;
        logic              abort;
    } shf_t;

    shf_t st_d, st_q;
    logic fs_fall, fs_rise, sc_fall;
    logic [WORD_W-1:0] sh_next;

    always_comb begin
        st_d         = st_q;
        st_d.prev_fs = fs_i;
        st_d.prev_sc = sc_i;
        st_d.vld     = 1'b0;
        st_d.abort   = 1'b0;
        fs_fall      = st_q.prev_fs & ~fs_i;
        fs_rise      = ~st_q.prev_fs & fs_i;
        sc_fall      = st_q.prev_sc & ~sc_i;
        sh_next      = {st_q.shreg[WORD_W-2:0], sd_i};

        if (fs_rise) begin
            if (st_q.active && st_q.cnt != '0 && st_q.cnt < CNT_W'(WORD_W)) begin
                st_d.abort = 1'b1;
            end
            st_d.active = 1'b0;
            st_d.cnt    = '0;
            st_d.shreg  = '0;
        end else if (fs_fall) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.shreg  = '0;
        end else if (st_q.active && !fs_i && sc_fall && st_q.cnt < CNT_W'(WORD_W)) begin
            st_d.shreg = sh_next;
            st_d.cnt   = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(WORD_W - 1)) begin
                st_d.vld = 1'b1;
                st_d.cmd = sh_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.prev_fs <= 1'b1;
            st_q.prev_sc <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_vld_o = st_q.vld;
    assign cmd_o     = st_q.cmd;
    assign abort_o   = st_q.abort;

    // R7
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(WORD_W));

    // R4
    abort_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.abort |-> st_q.prev_fs);

    // R7
    no_shift_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_W'(WORD_W) && !fs_rise && !fs_fall) |=> $stable(st_q.shreg));
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
    import sdac_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld_i,
    input  logic [WORD_W-1:0] cmd_i,
    output logic [CODE_W-1:0] code_o,
    output logic [1:0]        mode_o,
    output logic              pd_o,
    output logic              ok_o
);
    localparam int CODE_LO = DATA_W - CODE_W;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        mode_e             mode;
        logic              pd;
        logic              ok;
    } reg_t;

    reg_t rg_d, rg_q;
    mode_e cmd_mode;

    always_comb begin
        rg_d     = rg_q;
        rg_d.ok  = cmd_vld_i;
        cmd_mode = mode_e'(cmd_i[WORD_W-1 -: 2]);
        if (cmd_vld_i) begin
            rg_d.mode = cmd_mode;
            rg_d.pd   = (cmd_mode != MODE_RUN);
            if (cmd_mode == MODE_RUN) begin
                rg_d.code = cmd_i[DATA_W-1:CODE_LO];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '{code: '0, mode: MODE_RUN, pd: 1'b0, ok: 1'b0};
        end else begin
            rg_q <= rg_d;
        end
    end

    assign code_o = rg_q.code;
    assign mode_o = rg_q.mode;
    assign pd_o   = rg_q.pd;
    assign ok_o   = rg_q.ok;

    // R6
    code_hold_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_i && cmd_i[WORD_W-1 -: 2] != 2'b00) |=> $stable(rg_q.code));

    // R4
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld_i |=> ($stable(rg_q.code) && $stable(rg_q.mode) && $stable(rg_q.pd)));
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
    import sdac_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync_n,
    input  logic              sclk,
    input  logic              sdin,
    output logic [CODE_W-1:0] code_o,
    output logic              pwr_dn_o,
    output logic [1:0]        term_sel_o,
    output logic              frame_ok_o,
    output logic              frame_abort_o
);
    logic [2:0]        pins_sync;
    logic              cmd_vld;
    logic [WORD_W-1:0] cmd;

    sdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({fsync_n, sclk, sdin}),
        .sync_o  (pins_sync)
    );

    sdac_shifter u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs_i      (pins_sync[2]),
        .sc_i      (pins_sync[1]),
        .sd_i      (pins_sync[0]),
        .cmd_vld_o (cmd_vld),
        .cmd_o     (cmd),
        .abort_o   (frame_abort_o)
    );

    sdac_regs #(.CODE_W(CODE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_vld_i (cmd_vld),
        .cmd_i     (cmd),
        .code_o    (code_o),
        .mode_o    (term_sel_o),
        .pd_o      (pwr_dn_o),
        .ok_o      (frame_ok_o)
    );

    // R5
    pd_matches_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn_o == (term_sel_o != 2'b00));

    // R3
    ok_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok_o |=> !frame_ok_o);

    // R4
    ok_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_ok_o && frame_abort_o));

    // R1
    reset_out_chk: assert property (@(posedge clk)
        !rst_n |-> (code_o == '0 && !pwr_dn_o && term_sel_o == 2'b00));
endmodule

// File: tb/tb_sdac_frontend.sv
module tb_sdac_frontend;
    localparam int CODE_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync_n = 1'b1;
    logic sclk = 1'b1;
    logic sdin = 1'b0;
    logic [CODE_W-1:0] code_o;
    logic pwr_dn_o, frame_ok_o, frame_abort_o;
    logic [1:0] term_sel_o;

    int checks = 0, failures = 0;
    int n_ok = 0, n_abort = 0;
    bit done = 1'b0;
    logic [CODE_W-1:0] exp_code = '0;
    logic [1:0] exp_mode = 2'b00;

    always #2.5 clk = ~clk;

    sdac_frontend #(.CODE_W(CODE_W)) dut (
        .clk(clk), .rst_n(rst_n), .fsync_n(fsync_n), .sclk(sclk), .sdin(sdin),
        .code_o(code_o), .pwr_dn_o(pwr_dn_o), .term_sel_o(term_sel_o),
        .frame_ok_o(frame_ok_o), .frame_abort_o(frame_abort_o)
    );

    always @(negedge clk) begin
        if (frame_ok_o) n_ok++;
        if (frame_abort_o) n_abort++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [CODE_W-1:0] code_of(input logic [15:0] w);
        return w[13 -: CODE_W];
    endfunction

    // Sends nbits of w (MSB first), then extra falling clocks, then raises sync.
    task automatic send(input logic [15:0] w, input int nbits, input int extra);
        fsync_n = 1'b0;
        wclk(6);
        for (int i = 0; i < nbits + extra; i++) begin
            sdin = (i < 16) ? w[15 - i] : 1'($urandom);
            wclk(4);
            sclk = 1'b0;
            wclk(4);
            sclk = 1'b1;
        end
        wclk(6);
        fsync_n = 1'b1;
        wclk(10);
    endtask

    task automatic frame_check(input logic [15:0] w, input int nbits, input int extra);
        int ok0, ab0;
        ok0 = n_ok;
        ab0 = n_abort;
        send(w, nbits, extra);
        if (nbits == 16) begin
            exp_mode = w[15:14];
            if (w[15:14] == 2'b00) exp_code = code_of(w);
            chk(n_ok == ok0 + 1, "R3 one ok pulse", n_ok - ok0, 1);
            chk(n_abort == ab0, "R7 no abort after full frame", n_abort - ab0, 0);
        end else begin
            chk(n_ok == ok0, "R4 no ok on short frame", n_ok - ok0, 0);
            chk(n_abort == ab0 + ((nbits > 0) ? 1 : 0), "R4 abort pulse count",
                n_abort - ab0, (nbits > 0) ? 1 : 0);
        end
        chk(code_o == exp_code, "R2 R6 code", code_o, exp_code);
        chk(term_sel_o == exp_mode, "R5 termination select", term_sel_o, exp_mode);
        chk(pwr_dn_o == (exp_mode != 2'b00), "R5 power-down", pwr_dn_o, exp_mode != 2'b00);
    endtask

    initial begin
        #1ms;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        wclk(5);
        chk(code_o == '0, "R1 reset code", code_o, 0);
        chk(!pwr_dn_o && term_sel_o == 2'b00, "R1 reset mode", term_sel_o, 0);
        rst_n = 1'b1;
        wclk(5);
        chk(!frame_ok_o && !frame_abort_o && n_ok == 0, "R1 no pulses", n_ok, 0);

        frame_check(16'h3FFF, 16, 0);                  // R2 full scale
        chk(code_o == 12'hFFF, "R2 full scale", code_o, 12'hFFF);
        frame_check(16'h2000, 16, 0);                  // R2 MSB first
        chk(code_o == 12'h800, "R2 msb position", code_o, 12'h800);
        frame_check(16'h0003, 16, 0);                  // R2 low bits ignored
        chk(code_o == 12'h000, "R2 low bits ignored", code_o, 0);
        frame_check(16'h1234, 16, 0);
        frame_check(16'h4ABC, 16, 0);                  // R6 power-down keeps code
        chk(code_o == code_of(16'h1234), "R6 code kept in power-down", code_o, code_of(16'h1234));
        frame_check(16'hC000, 16, 0);                  // R5 open output
        frame_check(16'h8555, 16, 0);
        frame_check(16'h0FF0, 15, 0);                  // R4 abort at 15
        frame_check(16'h0000, 1, 0);                   // R4 abort at 1
        frame_check(16'h0000, 0, 0);                   // R4 zero-length frame
        frame_check(16'h2AAA, 16, 0);                  // R8 clean after abort
        chk(code_o == code_of(16'h2AAA), "R8 clean frame after abort", code_o, code_of(16'h2AAA));
        frame_check(16'h1111, 16, 5);                  // R7 trailing clocks ignored
        chk(code_o == code_of(16'h1111), "R7 trailing clocks", code_o, code_of(16'h1111));

        for (int k = 0; k < 60; k++) begin
            logic [15:0] w;
            int sel;
            w   = 16'($urandom);
            sel = int'($urandom % 4);
            if (sel == 0) frame_check(w, 1 + int'($urandom % 15), 0);
            else frame_check(w, 16, int'($urandom % 3));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule